// File: doc/BRIEF.md
# Scratch-Pad Integer ALU Unit

This block is a 16-bit integer unit for address arithmetic, built around a file of sixteen 16-bit registers. Every clock cycle it receives an opcode, a source register index, a destination register index, a post-shift code, a no-load flag and a bit-reverse flag. From these it forms a combinational function output and updates three registered status bits: negative (N), zero (Z) and carry (C). The next instruction tests those status bits.

Besides arithmetic and logic, the unit loads a register from three places: a panel bus, the exponent field of a floating-point data word, and two mantissa fields of that word. While it loads, it converts these floating-point fields into integers. On a cycle with opcode 0 (idle) the unit does not change state. The function output then shows the last operation executed again on the current register contents, so downstream logic always sees a meaningful value.

Bits are numbered with bit 15 as the most significant bit (MSB) throughout.

Top module: `spad_alu`

## Requirements
- R1: Let D be the destination register and S the source operand. The result for each opcode is:
  - 1 = D+S
  - 2 = D−S
  - 3 = S
  - 4 = D AND S
  - 5 = D OR S
  - 6 = NOT(D XOR S)
  - 7 = 0
  - 8 = D+1
  - 9 = D−1
  - 10 = NOT D

  All results are modulo 2^16. Opcode 15 is reserved and is not driven.
- R2: The carry for each opcode is:
  - 1, 3 and 6: set when D+S ≥ 2^16
  - 2: the carry out of D+NOT(S)+1
  - 4: set when (D AND S)+D ≥ 2^16
  - 5 and 10: 0
  - 7: equal to D[15]
  - 8: set when D = 0xFFFF
  - 9: set when D ≠ 0
- R3: For opcodes 1 to 10 the shift code shifts the result after the ALU, with zero fill:
  - 0: no shift
  - 1: left by one; carry becomes the bit that leaves bit 15
  - 2: right by one; carry becomes the bit that leaves bit 0
  - 3: right by two; carry becomes bit 1 of the unshifted result

  When a shift is applied, its carry replaces the arithmetic carry. Load opcodes ignore the shift code.
- R4: For opcodes 1 to 10 the shifted result is written into the destination at the clock edge. When no-load is set, the destination is not written, but the function output and the status bits are still produced.
- R5: When bit-reverse is set, the source operand S is the source register with its 16 bits reversed and then shifted right, zero filled, by the 4-bit count on brev_sh_in.
- R6: On every non-zero opcode, N becomes bit 15 of the function output, Z becomes 1 exactly when the function output is zero, and C becomes the carry. All three are registered at the clock edge. On opcode 0 all status bits are held.
- R7: On opcode 0 no register is written. The function output equals the most recent non-zero operation executed again, with its stored indices, shift, bit-reverse setting and count, on the current register values. Until the first operation after reset the function output is 0.
- R8: The load opcodes are 11 (panel), 12 (exponent), 13 (integer) and 14 (table). For each of them the function output, and therefore N and Z, is the old destination value and C is set to 1. The new value is always written to the destination, regardless of no-load.
- R9: Exponent load (opcode 12) writes the 10-bit biased exponent exp_in minus 512, as a 16-bit two's-complement value. exp_in[9] is inverted and extended into bits 15 to 9; exp_in[8:0] goes to bits 8 to 0.
- R10: The panel load (opcode 11) writes panel_in. The integer load (opcode 13) writes man_in[15:0]. The table load (opcode 14) writes man_in[25:19] into bits 6 to 0 and clears bits 15 to 7.
- R11: Reset (rst_n low) clears all 16 registers, the three status bits and the stored last operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_in | input | 4 | Opcode (0 = idle) |
| src_in | input | 4 | Source register index |
| dst_in | input | 4 | Destination register index |
| shift_in | input | 2 | Post-shift code |
| noload_in | input | 1 | Suppress the destination write for opcodes 1 to 10 |
| brev_in | input | 1 | Bit-reverse the source operand |
| brev_sh_in | input | 4 | Right-shift count applied after the bit-reverse |
| panel_in | input | 16 | Panel bus value |
| exp_in | input | 10 | Biased exponent field of the data word |
| man_in | input | 28 | Mantissa field of the data word |
| fn_out | output | 16 | Function output |
| flag_n | output | 1 | Negative status |
| flag_z | output | 1 | Zero status |
| flag_c | output | 1 | Carry status |

## Verification
The assertions check several properties on every cycle:
- N and Z follow the function output of the previous operation cycle.
- Idle cycles hold the status bits and never write.
- Load opcodes always set C.
- OR without a shift clears C.
- No-load blocks the write for opcodes 1 to 10.

Only the bench scenarios can show the rest, because each depends on register contents over time:
- every opcode's result and carry value
- the shift override
- the bit-reverse operand
- the field mappings of the three data loads
- idle replay seeing values written after the replayed operation

The bench reads each register back with a no-load move.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MOV  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_EQV  = 4'd6,
    OP_CLR  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_COM  = 4'd10,
    OP_LDPN = 4'd11,
    OP_LDEX = 4'd12,
    OP_LDIN = 4'd13,
    OP_LDTB = 4'd14,
    OP_RSV  = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_L    = 2'd1,
    SH_R    = 2'd2,
    SH_RR   = 2'd3
  } shift_e;

  function automatic logic op_is_load(op_e op);
    return (op == OP_LDPN) || (op == OP_LDEX) || (op == OP_LDIN) || (op == OP_LDTB);
  endfunction

endpackage

// File: rtl/spad_regfile.sv
module spad_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra_d,
  input  logic [AW-1:0] ra_s,
  output logic [DW-1:0] rd_d,
  output logic [DW-1:0] rd_s
);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (wa == AW'(g)))
        regs[g] <= wd;
    end
  end

  assign rd_d = regs[ra_d];
  assign rd_s = regs[ra_s];

endmodule

// File: rtl/spad_exec.sv
module spad_exec
  import spad_pkg::*;
#(
  parameter int DW   = 16,
  parameter int EW   = 10,
  parameter int MW   = 28,
  parameter int TW   = 7,
  localparam int BRW = $clog2(DW)
) (
  input  op_e            op,
  input  shift_e         shf,
  input  logic           brev,
  input  logic [BRW-1:0] brev_sh,
  input  logic [DW-1:0]  d_val,
  input  logic [DW-1:0]  s_val,
  input  logic [DW-1:0]  panel,
  input  logic [EW-1:0]  expo,
  input  logic [MW-1:0]  man,
  output logic [DW-1:0]  fn,
  output logic           carry,
  output logic [DW-1:0]  wdata
);

  function automatic logic [DW-1:0] bit_rev(logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
    return r;
  endfunction

  // Carry-out of an unsigned DW-bit sum.
  function automatic logic sum_cy(logic [DW-1:0] a, logic [DW-1:0] b, logic cin);
    logic [DW:0] t;
    t = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    return t[DW];
  endfunction

  // Integer value of a biased exponent field.
  function automatic logic [DW-1:0] exp_to_int(logic [EW-1:0] e);
    return {{(DW-EW+1){~e[EW-1]}}, e[EW-2:0]};
  endfunction

  logic [DW-1:0] s_op;
  logic [DW-1:0] alu_r;
  logic          alu_c;
  logic [DW-1:0] ld_val;

  assign s_op = brev ? (bit_rev(s_val) >> brev_sh) : s_val;

  always_comb begin
    alu_r = '0;
    alu_c = 1'b0;
    unique case (op)
      OP_ADD:  begin alu_r = d_val + s_op;    alu_c = sum_cy(d_val, s_op, 1'b0); end
      OP_SUB:  begin alu_r = d_val - s_op;    alu_c = sum_cy(d_val, ~s_op, 1'b1); end
      OP_MOV:  begin alu_r = s_op;            alu_c = sum_cy(d_val, s_op, 1'b0); end
      OP_AND:  begin alu_r = d_val & s_op;    alu_c = sum_cy(d_val & s_op, d_val, 1'b0); end
      OP_OR:   begin alu_r = d_val | s_op;    alu_c = 1'b0; end
      OP_EQV:  begin alu_r = ~(d_val ^ s_op); alu_c = sum_cy(d_val, s_op, 1'b0); end
      OP_CLR:  begin alu_r = '0;              alu_c = d_val[DW-1]; end
      OP_INC:  begin alu_r = d_val + 1'b1;    alu_c = &d_val; end
      OP_DEC:  begin alu_r = d_val - 1'b1;    alu_c = |d_val; end
      OP_COM:  begin alu_r = ~d_val;          alu_c = 1'b0; end
      OP_LDPN, OP_LDEX, OP_LDIN, OP_LDTB:
               begin alu_r = d_val;           alu_c = 1'b1; end
      default: begin alu_r = '0;              alu_c = 1'b0; end
    endcase
  end

  always_comb begin
    fn    = alu_r;
    carry = alu_c;
    if (!op_is_load(op)) begin
      unique case (shf)
        SH_L:    begin fn = {alu_r[DW-2:0], 1'b0}; carry = alu_r[DW-1]; end
        SH_R:    begin fn = {1'b0, alu_r[DW-1:1]}; carry = alu_r[0]; end
        SH_RR:   begin fn = {2'b00, alu_r[DW-1:2]}; carry = alu_r[1]; end
        default: begin fn = alu_r; carry = alu_c; end
      endcase
    end
  end

  always_comb begin
    unique case (op)
      OP_LDPN: ld_val = panel;
      OP_LDEX: ld_val = exp_to_int(expo);
      OP_LDIN: ld_val = man[DW-1:0];
      OP_LDTB: ld_val = {{(DW-TW){1'b0}}, man[MW-3 -: TW]};
      default: ld_val = '0;
    endcase
  end

  assign wdata = op_is_load(op) ? ld_val : fn;

endmodule

// File: rtl/spad_alu.sv
module spad_alu
  import spad_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 16,
  parameter int EW   = 10,
  parameter int MW   = 28,
  parameter int TW   = 7,
  localparam int AW  = $clog2(NREG),
  localparam int BRW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     op_in,
  input  logic [AW-1:0]  src_in,
  input  logic [AW-1:0]  dst_in,
  input  logic [1:0]     shift_in,
  input  logic           noload_in,
  input  logic           brev_in,
  input  logic [BRW-1:0] brev_sh_in,
  input  logic [DW-1:0]  panel_in,
  input  logic [EW-1:0]  exp_in,
  input  logic [MW-1:0]  man_in,
  output logic [DW-1:0]  fn_out,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flag_c
);

  op_e            cur_op;
  logic           is_cur;
  logic           wr_en;

  op_e            last_op;
  logic [AW-1:0]  last_src, last_dst;
  shift_e         last_sh;
  logic           last_br;
  logic [BRW-1:0] last_bs;

  op_e            eff_op;
  logic [AW-1:0]  eff_src, eff_dst;
  shift_e         eff_sh;
  logic           eff_br;
  logic [BRW-1:0] eff_bs;

  logic [DW-1:0]  d_val, s_val, fn, wdata;
  logic           carry;

  assign cur_op = op_e'(op_in);
  assign is_cur = (cur_op != OP_NOP);

  // Idle cycles replay the stored operation on the current register values.
  assign eff_op  = is_cur ? cur_op             : last_op;
  assign eff_src = is_cur ? src_in             : last_src;
  assign eff_dst = is_cur ? dst_in             : last_dst;
  assign eff_sh  = is_cur ? shift_e'(shift_in) : last_sh;
  assign eff_br  = is_cur ? brev_in            : last_br;
  assign eff_bs  = is_cur ? brev_sh_in         : last_bs;

  assign wr_en = is_cur && (op_is_load(cur_op) || !noload_in);

  spad_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .wa   (dst_in),
    .wd   (wdata),
    .ra_d (eff_dst),
    .ra_s (eff_src),
    .rd_d (d_val),
    .rd_s (s_val)
  );

  spad_exec #(.DW(DW), .EW(EW), .MW(MW), .TW(TW)) u_exec (
    .op     (eff_op),
    .shf    (eff_sh),
    .brev   (eff_br),
    .brev_sh(eff_bs),
    .d_val  (d_val),
    .s_val  (s_val),
    .panel  (panel_in),
    .expo   (exp_in),
    .man    (man_in),
    .fn     (fn),
    .carry  (carry),
    .wdata  (wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op  <= OP_NOP;
      last_src <= '0;
      last_dst <= '0;
      last_sh  <= SH_NONE;
      last_br  <= 1'b0;
      last_bs  <= '0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
      flag_c   <= 1'b0;
    end else if (is_cur) begin
      last_op  <= cur_op;
      last_src <= src_in;
      last_dst <= dst_in;
      last_sh  <= shift_e'(shift_in);
      last_br  <= brev_in;
      last_bs  <= brev_sh_in;
      flag_n   <= fn[DW-1];
      flag_z   <= (fn == '0);
      flag_c   <= carry;
    end
  end

  assign fn_out = fn;

endmodule

// File: rtl/spad_alu_chk.sv
module spad_alu_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_in,
  input logic [1:0]    shift_in,
  input logic          noload_in,
  input logic          wr_en,
  input logic [DW-1:0] fn_out,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_c
);

  a_r6_idle_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in == 4'd0) |=> $stable({flag_n, flag_z, flag_c}));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in != 4'd0) |=> (flag_z == ($past(fn_out) == '0)));

  a_r6_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in != 4'd0) |=> (flag_n == $past(fn_out[DW-1])));

  a_r8_load_sets_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in >= 4'd11 && op_in <= 4'd14) |=> flag_c);

  a_r2_or_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in == 4'd5 && shift_in == 2'd0) |=> !flag_c);

  a_r4_noload_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (noload_in && op_in >= 4'd1 && op_in <= 4'd10) |-> !wr_en);

  a_r7_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in == 4'd0) |-> !wr_en);

endmodule

bind spad_alu spad_alu_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_in    (op_in),
  .shift_in (shift_in),
  .noload_in(noload_in),
  .wr_en    (wr_en),
  .fn_out   (fn_out),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_c   (flag_c)
);

// File: tb/tb_spad_alu.sv
module tb_spad_alu;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_in = '0;
  logic [3:0]  src_in = '0, dst_in = '0;
  logic [1:0]  shift_in = '0;
  logic        noload_in = 1'b0, brev_in = 1'b0;
  logic [3:0]  brev_sh_in = '0;
  logic [15:0] panel_in = '0;
  logic [9:0]  exp_in = '0;
  logic [27:0] man_in = '0;
  logic [15:0] fn_out;
  logic        flag_n, flag_z, flag_c;

  always #(PERIOD/2) clk = ~clk;

  spad_alu dut (
    .clk(clk), .rst_n(rst_n), .op_in(op_in), .src_in(src_in), .dst_in(dst_in),
    .shift_in(shift_in), .noload_in(noload_in), .brev_in(brev_in),
    .brev_sh_in(brev_sh_in), .panel_in(panel_in), .exp_in(exp_in),
    .man_in(man_in), .fn_out(fn_out), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int mreg [16];
  int l_op = 0, l_src = 0, l_dst = 0, l_sh = 0, l_br = 0, l_bs = 0;
  int m_n = 0, m_z = 0, m_c = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of one operation, per the requirements.
  task automatic mexec(input int op, input int sh, input int br, input int bs,
                       input int d, input int s, input int pan, input int e,
                       input int man, output int fn, output int c, output int wd);
    int so, r, cc;
    so = s;
    if (br != 0) begin
      int t = 0;
      for (int i = 0; i < 16; i++) if (((s >> i) & 1) == 1) t = t | (1 << (15 - i));
      so = t >> bs;
    end
    r = 0; cc = 0;
    case (op)
      1: begin r = d + so; cc = (r >= 65536); r = r & 16'hFFFF; end
      2: begin r = d + (so ^ 16'hFFFF) + 1; cc = (r >= 65536); r = r & 16'hFFFF; end
      3: begin r = so; cc = ((d + so) >= 65536); end
      4: begin r = d & so; cc = (((d & so) + d) >= 65536); end
      5: begin r = d | so; cc = 0; end
      6: begin r = (~(d ^ so)) & 16'hFFFF; cc = ((d + so) >= 65536); end
      7: begin r = 0; cc = (d >= 32768); end
      8: begin r = (d + 1) & 16'hFFFF; cc = (d == 16'hFFFF); end
      9: begin r = (d - 1) & 16'hFFFF; cc = (d != 0); end
      10: begin r = (~d) & 16'hFFFF; cc = 0; end
      11, 12, 13, 14: begin r = d; cc = 1; end
      default: begin r = 0; cc = 0; end
    endcase
    if (op >= 1 && op <= 10) begin
      if (sh == 1) begin cc = (r >> 15) & 1; r = (r << 1) & 16'hFFFF; end
      else if (sh == 2) begin cc = r & 1; r = r >> 1; end
      else if (sh == 3) begin cc = (r >> 1) & 1; r = r >> 2; end
    end
    fn = r; c = cc;
    case (op)
      11: wd = pan & 16'hFFFF;
      12: wd = (e - 512) & 16'hFFFF;
      13: wd = man & 16'hFFFF;
      14: wd = (man >> 19) & 8'h7F;
      default: wd = r;
    endcase
  endtask

  task automatic step(input int op, input int src, input int dst, input int sh,
                      input int nl, input int br, input int bs, input int pan,
                      input int e, input int man, input string tag);
    int efn, ec, ewd;
    @(negedge clk);
    op_in = op[3:0]; src_in = src[3:0]; dst_in = dst[3:0]; shift_in = sh[1:0];
    noload_in = nl[0]; brev_in = br[0]; brev_sh_in = bs[3:0];
    panel_in = pan[15:0]; exp_in = e[9:0]; man_in = man[27:0];
    #1;
    if (op != 0) mexec(op, sh, br, bs, mreg[dst], mreg[src], pan, e, man, efn, ec, ewd);
    else mexec(l_op, l_sh, l_br, l_bs, mreg[l_dst], mreg[l_src], 0, 0, 0, efn, ec, ewd);
    chk({tag, " fn_out"}, int'(fn_out), efn);
    @(posedge clk);
    #1;
    if (op != 0) begin
      m_n = (efn >> 15) & 1; m_z = (efn == 0); m_c = ec;
      if (op >= 11 || nl == 0) mreg[dst] = ewd;
      l_op = op; l_src = src; l_dst = dst; l_sh = sh; l_br = br; l_bs = bs;
    end
    chk({tag, " flags"}, int'({flag_n, flag_z, flag_c}), (m_n << 2) | (m_z << 1) | m_c);
  endtask

  // Read a register back through a no-load move and compare it.
  task automatic rdback(input int idx, input int exp, input string tag);
    step(3, idx, idx, 0, 1, 0, 0, 0, 0, 0, tag);
    chk({tag, " readback"}, mreg[idx], exp);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 16; i++) mreg[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11 reset fn_out", int'(fn_out), 0);
    chk("R11 reset flags", int'({flag_n, flag_z, flag_c}), 0);
    rdback(7, 0, "R11 reg clear");

    // R8 R10 panel load: output shows old value, carry forced, new value written
    step(11, 0, 1, 0, 1, 0, 0, 16'hFFFF, 0, 0, "R8 panel load");
    rdback(1, 16'hFFFF, "R10 panel");
    step(13, 0, 2, 0, 0, 0, 0, 0, 0, 28'hABC0001, "R10 integer load");
    rdback(2, 1, "R10 integer");
    // R1 R2 add wraps with carry
    step(1, 2, 1, 0, 0, 0, 0, 0, 0, 0, "R1 R2 add overflow");
    rdback(1, 0, "R1 add result");
    step(2, 2, 1, 0, 0, 0, 0, 0, 0, 0, "R2 sub borrow");
    rdback(1, 16'hFFFF, "R1 sub result");
    // R3 shift overrides carry; R4 no-load keeps destination
    step(1, 2, 1, 1, 1, 0, 0, 0, 0, 0, "R3 left shift carry override");
    step(3, 1, 1, 2, 1, 0, 0, 0, 0, 0, "R3 right shift");
    step(13, 0, 3, 0, 0, 0, 0, 0, 0, 2, "R10 integer load 2");
    step(3, 3, 3, 3, 1, 0, 0, 0, 0, 0, "R3 double right shift");
    step(12, 0, 3, 2, 0, 0, 0, 0, 0, 0, "R3 load ignores shift");
    rdback(1, 16'hFFFF, "R4 no-load kept");
    // R9 exponent conversion
    step(12, 0, 4, 0, 0, 0, 0, 0, 512, 0, "R9 exp 512");
    rdback(4, 0, "R9 exp 512");
    step(12, 0, 4, 0, 0, 0, 0, 0, 513, 0, "R9 exp 513");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 replay after load");
    rdback(4, 1, "R9 exp 513");
    step(12, 0, 4, 0, 0, 0, 0, 0, 511, 0, "R9 exp 511");
    rdback(4, 16'hFFFF, "R9 exp 511");
    // R10 table load
    step(14, 0, 5, 0, 0, 0, 0, 0, 0, 28'hFFFFFFF & ~(28'h7F << 19) | (28'h5A << 19), "R10 table load");
    rdback(5, 16'h005A, "R10 table");
    // R5 bit reverse
    step(3, 2, 6, 0, 0, 1, 12, 0, 0, 0, "R5 bit reverse");
    rdback(6, 16'h0008, "R5 bit reverse");
    // R7 replay sees new value; R6 flags held
    step(8, 0, 6, 0, 0, 0, 0, 0, 0, 0, "R1 inc");
    step(0, 3, 9, 1, 0, 1, 3, 0, 0, 0, "R6 R7 idle replay");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 R7 idle replay 2");
    step(7, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 clr carry");
    step(9, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 dec of zero");
    step(5, 4, 5, 0, 0, 0, 0, 0, 0, 0, "R2 or carry");

    // Constrained random mix, R1 to R10
    for (int k = 0; k < 3000; k++) begin
      int op, sh, nl, br;
      op = (($urandom % 5) == 0) ? 0 : int'($urandom_range(1, 14));
      sh = int'($urandom % 4);
      nl = (($urandom % 3) == 0) ? 1 : 0;
      br = (($urandom % 4) == 0) ? 1 : 0;
      step(op, int'($urandom % 16), int'($urandom % 16), sh, nl, br,
           int'($urandom % 16), int'($urandom & 16'hFFFF), int'($urandom % 1024),
           int'($urandom & 28'hFFFFFFF), "R1 R2 R3 R7 random");
    end
    for (int i = 0; i < 16; i++) rdback(i, mreg[i], "R4 R8 final regs");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule